// File: doc/BRIEF.md
# NAND Flash Bus Cycle Sequencer

This block sits on the host side of an 8-bit NAND flash device bus. It turns one request into the strobe and data waveforms of the device bus. A request names one of four cycle kinds: a single command byte, a full address, a burst of written bytes or a burst of read bytes. The block drives chip enable, the two latch-enable lines, write enable and read enable. It also drives the outgoing half of a tristated data bus together with its output enable, and it returns each byte read from the device on a one-cycle valid strobe.

Every strobe phase width is a parameter counted in clock cycles, and the minimum is one cycle. The device rejects very short pulses as glitches, so the block never emits a low or high phase shorter than the configured count. A request is accepted through a valid/ready handshake. After the high phase that follows the last strobe of the request, the block raises a one-cycle done pulse. Chip enable is high whenever the block is idle.

Top module: `nand_bus_seq`

## Requirements
- R1: Request kind 0 (`req_op` = 2'd0) issues one command cycle: chip enable low, command latch high, address latch low, read enable high, one write-enable pulse, and the device sees `req_cmd` on the data lines at the rising edge of write enable.
- R2: Request kind 1 issues exactly five address cycles back to back, with address latch high, command latch low and read enable high. The bytes of `req_addr` go out least significant byte first, so byte k is `req_addr[8k+7:8k]`.
- R3: Request kind 2 writes `req_len`+1 bytes, with both latch lines low and read enable high. Each byte is taken from `wr_data` in the cycle where `wr_pop` is high, with exactly one pop per byte, and it reaches the device in order at a write-enable rising edge. The data lines stay stable while write enable is low.
- R4: Request kind 3 produces `req_len`+1 read-enable pulses, with both latch lines low and write enable high. The bus value on the last clock of each low phase is returned on `rd_data` with a one-cycle `rd_valid`.
- R5: Each write-enable low phase lasts exactly WE_LOW clocks and each read-enable low phase lasts exactly RE_LOW clocks. Between two bytes of one request the strobe stays high for exactly WE_HIGH or RE_HIGH clocks.
- R6: After chip enable falls, both strobes stay high for exactly SETUP_CYC clocks before the first strobe goes low.
- R7: `nand_dq_oe` is high during command, address and write requests. It is low for the whole of a read request, and it is already low at least one clock before read enable first falls.
- R8: `req_ready` is high only while idle, and chip enable is then high. A request takes SETUP_CYC + n*(low+high) busy clocks for n bytes, and then `done` is high for exactly one clock, in the first idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted this cycle if valid |
| req_op | input | 2 | Kind: 0 command, 1 address, 2 write, 3 read |
| req_cmd | input | 8 | Command byte |
| req_addr | input | 40 | Five address bytes, low byte first on the bus |
| req_len | input | LEN_W | Burst byte count minus one |
| wr_data | input | 8 | Next byte to write |
| wr_pop | output | 1 | `wr_data` consumed this cycle |
| rd_data | output | 8 | Byte read from the device |
| rd_valid | output | 1 | `rd_data` valid for one cycle |
| done | output | 1 | Request finished |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write enable, active low |
| nand_re_n | output | 1 | Read enable, active low |
| nand_dq_o | output | 8 | Data bus value driven to the device |
| nand_dq_oe | output | 1 | Data bus output enable |
| nand_dq_i | input | 8 | Data bus value from the device |

## Verification
The command path is swept across sixteen byte values. The address path is tried with a walking one through all forty bits, together with all-zero, all-one and counting patterns. The walking one shows that each bus byte comes from the right slice of the address and goes out in the right order. Write and read bursts are swept over every length from one to sixteen bytes, with data generated arithmetically per byte index. This separates off-by-one errors in the byte count, missing or extra pops, and capture on the wrong clock. Every transfer also measures each strobe phase, the setup gap, the output-enable release and the exact busy length, so that errors in the timer and in the phase sequencing are told apart from errors in the data path.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

   localparam int unsigned BYTE_W      = 8;
   localparam int unsigned ADDR_CYCLES = 5;

   typedef enum logic [1:0] {
      OP_CMD   = 2'd0,
      OP_ADDR  = 2'd1,
      OP_WRITE = 2'd2,
      OP_READ  = 2'd3
   } nand_op_e;

   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_SETUP = 2'd1,
      PH_LOW   = 2'd2,
      PH_HIGH  = 2'd3
   } nand_phase_e;

   function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/nand_seq_timer.sv
module nand_seq_timer #(
   parameter int unsigned CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expired = (cnt_q == '0);

endmodule

// File: rtl/nand_seq_ctrl.sv
module nand_seq_ctrl
   import nand_seq_pkg::*;
#(
   parameter int unsigned LEN_W     = 8,
   parameter int unsigned CNT_W     = 4,
   parameter int unsigned SETUP_CYC = 1,
   parameter int unsigned WE_LOW    = 1,
   parameter int unsigned WE_HIGH   = 1,
   parameter int unsigned RE_LOW    = 1,
   parameter int unsigned RE_HIGH   = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  nand_op_e          req_op,
   input  logic [LEN_W-1:0]  req_len,
   input  logic              tmr_expired,
   output logic              req_ready,
   output nand_phase_e       phase,
   output nand_op_e          op_q,
   output logic              tmr_load,
   output logic [CNT_W-1:0]  tmr_val,
   output logic              accept,
   output logic              advance,
   output logic              capture,
   output logic              done
);

   localparam logic [CNT_W-1:0] SETUP_LD  = CNT_W'(SETUP_CYC - 1);
   localparam logic [CNT_W-1:0] WE_LO_LD  = CNT_W'(WE_LOW - 1);
   localparam logic [CNT_W-1:0] WE_HI_LD  = CNT_W'(WE_HIGH - 1);
   localparam logic [CNT_W-1:0] RE_LO_LD  = CNT_W'(RE_LOW - 1);
   localparam logic [CNT_W-1:0] RE_HI_LD  = CNT_W'(RE_HIGH - 1);
   localparam logic [LEN_W-1:0] ADDR_LAST = LEN_W'(ADDR_CYCLES - 1);

   nand_phase_e      phase_d;
   logic [LEN_W-1:0] byte_q;
   logic [LEN_W-1:0] last_q;
   logic             is_rd;
   logic             last_byte;
   logic             finish;
   logic [CNT_W-1:0] lo_ld;
   logic [CNT_W-1:0] hi_ld;

   assign is_rd     = (op_q == OP_READ);
   assign lo_ld     = is_rd ? RE_LO_LD : WE_LO_LD;
   assign hi_ld     = is_rd ? RE_HI_LD : WE_HI_LD;
   assign last_byte = (byte_q == last_q);
   assign req_ready = (phase == PH_IDLE);
   assign accept    = req_ready && req_valid;
   assign advance   = (phase == PH_HIGH) && tmr_expired && !last_byte;
   assign finish    = (phase == PH_HIGH) && tmr_expired && last_byte;
   assign capture   = (phase == PH_LOW) && tmr_expired && is_rd;

   always_comb begin
      phase_d  = phase;
      tmr_load = 1'b0;
      tmr_val  = '0;
      case (phase)
         PH_IDLE: begin
            if (req_valid) begin
               phase_d  = PH_SETUP;
               tmr_load = 1'b1;
               tmr_val  = SETUP_LD;
            end
         end
         PH_SETUP: begin
            if (tmr_expired) begin
               phase_d  = PH_LOW;
               tmr_load = 1'b1;
               tmr_val  = lo_ld;
            end
         end
         PH_LOW: begin
            if (tmr_expired) begin
               phase_d  = PH_HIGH;
               tmr_load = 1'b1;
               tmr_val  = hi_ld;
            end
         end
         PH_HIGH: begin
            if (tmr_expired) begin
               if (last_byte) begin
                  phase_d = PH_IDLE;
               end else begin
                  phase_d  = PH_LOW;
                  tmr_load = 1'b1;
                  tmr_val  = lo_ld;
               end
            end
         end
         default: phase_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase  <= PH_IDLE;
         op_q   <= OP_CMD;
         byte_q <= '0;
         last_q <= '0;
         done   <= 1'b0;
      end else begin
         phase <= phase_d;
         done  <= finish;
         if (accept) begin
            op_q   <= req_op;
            byte_q <= '0;
            case (req_op)
               OP_CMD:  last_q <= '0;
               OP_ADDR: last_q <= ADDR_LAST;
               default: last_q <= req_len;
            endcase
         end else if (advance) begin
            byte_q <= byte_q + 1'b1;
         end
      end
   end

endmodule

// File: rtl/nand_seq_dp.sv
module nand_seq_dp
   import nand_seq_pkg::*;
#(
   parameter int unsigned ADDR_W = BYTE_W * ADDR_CYCLES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic              advance,
   input  logic              capture,
   input  nand_op_e          req_op,
   input  nand_op_e          op_q,
   input  logic [BYTE_W-1:0] req_cmd,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic [BYTE_W-1:0] dq_i,
   output logic [BYTE_W-1:0] dq_o,
   output logic              wr_pop,
   output logic [BYTE_W-1:0] rd_data,
   output logic              rd_valid
);

   logic [ADDR_W-1:0] addr_q;

   assign wr_pop = (accept && (req_op == OP_WRITE)) ||
                   (advance && (op_q == OP_WRITE));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q <= '0;
         dq_o   <= '0;
      end else if (accept) begin
         addr_q <= req_addr;
         case (req_op)
            OP_CMD:   dq_o <= req_cmd;
            OP_ADDR:  dq_o <= req_addr[BYTE_W-1:0];
            OP_WRITE: dq_o <= wr_data;
            default:  dq_o <= dq_o;
         endcase
      end else if (advance) begin
         if (op_q == OP_ADDR) begin
            addr_q <= addr_q >> BYTE_W;
            dq_o   <= addr_q[2*BYTE_W-1:BYTE_W];
         end else if (op_q == OP_WRITE) begin
            dq_o   <= wr_data;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_data  <= '0;
         rd_valid <= 1'b0;
      end else begin
         rd_valid <= capture;
         if (capture) begin
            rd_data <= dq_i;
         end
      end
   end

endmodule

// File: rtl/nand_bus_seq.sv
module nand_bus_seq
   import nand_seq_pkg::*;
#(
   parameter int unsigned LEN_W     = 8,
   parameter int unsigned SETUP_CYC = 1,
   parameter int unsigned WE_LOW    = 2,
   parameter int unsigned WE_HIGH   = 2,
   parameter int unsigned RE_LOW    = 2,
   parameter int unsigned RE_HIGH   = 2
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          req_valid,
   output logic                          req_ready,
   input  logic [1:0]                    req_op,
   input  logic [7:0]                    req_cmd,
   input  logic [8*ADDR_CYCLES-1:0]      req_addr,
   input  logic [LEN_W-1:0]              req_len,
   input  logic [7:0]                    wr_data,
   output logic                          wr_pop,
   output logic [7:0]                    rd_data,
   output logic                          rd_valid,
   output logic                          done,
   output logic                          nand_ce_n,
   output logic                          nand_cle,
   output logic                          nand_ale,
   output logic                          nand_we_n,
   output logic                          nand_re_n,
   output logic [7:0]                    nand_dq_o,
   output logic                          nand_dq_oe,
   input  logic [7:0]                    nand_dq_i
);

   localparam int unsigned ADDR_W  = BYTE_W * ADDR_CYCLES;
   localparam int unsigned MAX_PH  = max_u(max_u(max_u(WE_LOW, WE_HIGH),
                                                 max_u(RE_LOW, RE_HIGH)), SETUP_CYC);
   localparam int unsigned CNT_W   = max_u(1, $clog2(MAX_PH));

   if (SETUP_CYC < 1 || WE_LOW < 1 || WE_HIGH < 1 || RE_LOW < 1 || RE_HIGH < 1) begin : g_bad_timing
      $error("nand_bus_seq: every phase width must be at least one clock");
   end
   if (LEN_W < 3) begin : g_bad_len
      $error("nand_bus_seq: LEN_W must hold the address cycle count");
   end

   nand_op_e    op_in;
   nand_op_e    op_q;
   nand_phase_e phase;
   logic        tmr_load;
   logic [CNT_W-1:0] tmr_val;
   logic        tmr_expired;
   logic        accept;
   logic        advance;
   logic        capture;
   logic        active;

   assign op_in = nand_op_e'(req_op);

   nand_seq_timer #(.CNT_W(CNT_W)) i_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expired  (tmr_expired)
   );

   nand_seq_ctrl #(
      .LEN_W     (LEN_W),
      .CNT_W     (CNT_W),
      .SETUP_CYC (SETUP_CYC),
      .WE_LOW    (WE_LOW),
      .WE_HIGH   (WE_HIGH),
      .RE_LOW    (RE_LOW),
      .RE_HIGH   (RE_HIGH)
   ) i_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_valid   (req_valid),
      .req_op      (op_in),
      .req_len     (req_len),
      .tmr_expired (tmr_expired),
      .req_ready   (req_ready),
      .phase       (phase),
      .op_q        (op_q),
      .tmr_load    (tmr_load),
      .tmr_val     (tmr_val),
      .accept      (accept),
      .advance     (advance),
      .capture     (capture),
      .done        (done)
   );

   nand_seq_dp #(.ADDR_W(ADDR_W)) i_dp (
      .clk      (clk),
      .rst_n    (rst_n),
      .accept   (accept),
      .advance  (advance),
      .capture  (capture),
      .req_op   (op_in),
      .op_q     (op_q),
      .req_cmd  (req_cmd),
      .req_addr (req_addr),
      .wr_data  (wr_data),
      .dq_i     (nand_dq_i),
      .dq_o     (nand_dq_o),
      .wr_pop   (wr_pop),
      .rd_data  (rd_data),
      .rd_valid (rd_valid)
   );

   // Bus line decode: every term comes straight from two state registers.
   assign active     = (phase != PH_IDLE);
   assign nand_ce_n  = !active;
   assign nand_cle   = active && (op_q == OP_CMD);
   assign nand_ale   = active && (op_q == OP_ADDR);
   assign nand_we_n  = !((phase == PH_LOW) && (op_q != OP_READ));
   assign nand_re_n  = !((phase == PH_LOW) && (op_q == OP_READ));
   assign nand_dq_oe = active && (op_q != OP_READ);

endmodule

// File: rtl/nand_bus_seq_chk.sv
module nand_bus_seq_chk #(
   parameter int unsigned WE_LOW = 2,
   parameter int unsigned RE_LOW = 2
) (
   input logic       clk,
   input logic       rst_n,
   input logic       nand_ce_n,
   input logic       nand_cle,
   input logic       nand_ale,
   input logic       nand_we_n,
   input logic       nand_re_n,
   input logic       nand_dq_oe,
   input logic [7:0] nand_dq_o,
   input logic       req_ready,
   input logic       done,
   input logic       rd_valid
);

   logic [15:0] we_lo_cnt;
   logic [15:0] re_lo_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         we_lo_cnt <= '0;
         re_lo_cnt <= '0;
      end else begin
         we_lo_cnt <= nand_we_n ? '0 : we_lo_cnt + 1'b1;
         re_lo_cnt <= nand_re_n ? '0 : re_lo_cnt + 1'b1;
      end
   end

   AST_CMD_LINES: assert property (@(posedge clk) disable iff (!rst_n)
      nand_cle |-> (!nand_ce_n && !nand_ale && nand_re_n)); // R1
   AST_ADDR_LINES: assert property (@(posedge clk) disable iff (!rst_n)
      nand_ale |-> (!nand_ce_n && !nand_cle && nand_re_n)); // R2
   AST_WRITE_LINES: assert property (@(posedge clk) disable iff (!rst_n)
      !nand_we_n |-> (!nand_ce_n && nand_re_n && nand_dq_oe)); // R3
   AST_DQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!nand_we_n && $past(!nand_we_n)) |-> $stable(nand_dq_o)); // R3
   AST_READ_LINES: assert property (@(posedge clk) disable iff (!rst_n)
      !nand_re_n |-> (!nand_ce_n && nand_we_n && !nand_cle && !nand_ale && !nand_dq_oe)); // R4
   AST_RDV_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> !rd_valid); // R4
   AST_WE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(nand_we_n) |-> (we_lo_cnt == 16'(WE_LOW))); // R5
   AST_RE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(nand_re_n) |-> (re_lo_cnt == 16'(RE_LOW))); // R5
   AST_OE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(nand_re_n) |-> $past(!nand_dq_oe)); // R7
   AST_IDLE_CE: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> nand_ce_n); // R8
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R8

endmodule

bind nand_bus_seq nand_bus_seq_chk #(
   .WE_LOW (WE_LOW),
   .RE_LOW (RE_LOW)
) i_nand_bus_seq_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .nand_ce_n  (nand_ce_n),
   .nand_cle   (nand_cle),
   .nand_ale   (nand_ale),
   .nand_we_n  (nand_we_n),
   .nand_re_n  (nand_re_n),
   .nand_dq_oe (nand_dq_oe),
   .nand_dq_o  (nand_dq_o),
   .req_ready  (req_ready),
   .done       (done),
   .rd_valid   (rd_valid)
);

// File: tb/test_nand_bus_seq.sv
module test_nand_bus_seq;

   localparam int LEN_W = 4;
   localparam int SETUP = 2;
   localparam int WLO   = 2;
   localparam int WHI   = 1;
   localparam int RLO   = 3;
   localparam int RHI   = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [1:0]  req_op = 2'd0;
   logic [7:0]  req_cmd = 8'd0;
   logic [39:0] req_addr = 40'd0;
   logic [LEN_W-1:0] req_len = '0;
   logic [7:0]  wr_data;
   logic        wr_pop;
   logic [7:0]  rd_data;
   logic        rd_valid;
   logic        done;
   logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
   logic [7:0]  nand_dq_o;
   logic [7:0]  nand_dq_i;

   always #5 clk = ~clk;

   nand_bus_seq #(
      .LEN_W(LEN_W), .SETUP_CYC(SETUP), .WE_LOW(WLO), .WE_HIGH(WHI),
      .RE_LOW(RLO), .RE_HIGH(RHI)
   ) i_nand_bus_seq (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_op(req_op), .req_cmd(req_cmd), .req_addr(req_addr), .req_len(req_len),
      .wr_data(wr_data), .wr_pop(wr_pop), .rd_data(rd_data), .rd_valid(rd_valid),
      .done(done), .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
      .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_dq_o(nand_dq_o),
      .nand_dq_oe(nand_dq_oe), .nand_dq_i(nand_dq_i)
   );

   function automatic logic [7:0] wgen(input int i);
      return 8'((i * 37 + 11) & 255);
   endfunction
   function automatic logic [7:0] rgen(input int i);
      return 8'((i * 53 + 60) & 255);
   endfunction

   // Host write source
   int widx;
   always @(posedge clk) begin
      if (!rst_n) widx <= 0;
      else if (wr_pop) widx <= widx + 1;
   end
   assign wr_data = wgen(widx);

   // Device model and bus monitor
   int n_chk = 0, n_err = 0, m_chk = 0, m_err = 0;
   int ridx, we_lo, we_hi, re_lo, re_hi, pre_cnt, re_pulses, lg_n, rd_n;
   bit seen_strobe;
   logic prev_we, prev_re, prev_ce, prev_oe;
   logic [1:0] lg_kind [32];
   logic [7:0] lg_val  [32];
   logic [7:0] rd_log  [32];

   assign nand_dq_i = rgen(ridx);

   function automatic void mchk(input bit ok, input string rq, input int act, input int exp);
      m_chk++;
      if (!ok) begin
         m_err++;
         $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
      end
   endfunction

   function automatic void chk(input bit ok, input string rq, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
      end
   endfunction

   always @(negedge clk) begin
      if (!rst_n) begin
         ridx = 0; we_lo = 0; we_hi = 0; re_lo = 0; re_hi = 0; pre_cnt = 0;
         re_pulses = 0; lg_n = 0; rd_n = 0; seen_strobe = 0;
         prev_we = 1; prev_re = 1; prev_ce = 1; prev_oe = 0;
      end else begin
         if (prev_ce && !nand_ce_n) begin
            lg_n = 0; rd_n = 0; re_pulses = 0; pre_cnt = 0; seen_strobe = 0;
         end
         if (!nand_ce_n && !seen_strobe) begin
            if (nand_we_n && nand_re_n) pre_cnt++;
            else begin
               seen_strobe = 1;
               mchk(pre_cnt == SETUP, "R6 setup clocks", pre_cnt, SETUP);
            end
         end
         // write strobe
         if (!nand_we_n) begin
            if (prev_we && lg_n > 0)
               mchk(we_hi == WHI, "R5 write-enable high width", we_hi, WHI);
            we_lo++;
         end else if (!prev_we) begin
            mchk(we_lo == WLO, "R5 write-enable low width", we_lo, WLO);
            mchk(nand_dq_oe == 1'b1, "R7 output enable at write edge", int'(nand_dq_oe), 1);
            if (lg_n < 32) begin
               lg_kind[lg_n] = {nand_cle, nand_ale};
               lg_val[lg_n]  = nand_dq_o;
            end
            lg_n++;
            we_lo = 0; we_hi = 1;
         end else begin
            we_hi++;
         end
         // read strobe
         if (!nand_re_n) begin
            if (prev_re) begin
               mchk(!prev_oe && !nand_dq_oe, "R7 bus released before read", int'(prev_oe), 0);
               if (re_pulses > 0)
                  mchk(re_hi == RHI, "R5 read-enable high width", re_hi, RHI);
            end
            re_lo++;
         end else if (!prev_re) begin
            mchk(re_lo == RLO, "R5 read-enable low width", re_lo, RLO);
            re_pulses++; ridx++;
            re_lo = 0; re_hi = 1;
         end else begin
            re_hi++;
         end
         if (rd_valid) begin
            if (rd_n < 32) rd_log[rd_n] = rd_data;
            rd_n++;
         end
         prev_we = nand_we_n; prev_re = nand_re_n; prev_ce = nand_ce_n; prev_oe = nand_dq_oe;
      end
   end

   task automatic run(input logic [1:0] op, input logic [7:0] cmd,
                      input logic [39:0] addr, input int len);
      int wb, rb, nb, busy, t;
      wb = widx; rb = ridx;
      nb = (op == 2'd0) ? 1 : (op == 2'd1) ? 5 : len + 1;
      busy = SETUP + nb * ((op == 2'd3) ? (RLO + RHI) : (WLO + WHI));
      @(negedge clk);
      req_op = op; req_cmd = cmd; req_addr = addr; req_len = LEN_W'(len); req_valid = 1'b1;
      chk(req_ready && nand_ce_n, "R8 ready and chip enable high while idle",
          int'(req_ready), 1);
      @(negedge clk);
      req_valid = 1'b0;
      chk(!req_ready && !nand_ce_n, "R8 busy after accept", int'(req_ready), 0);
      t = 1;
      while (!done && t < 4000) begin
         @(negedge clk);
         t++;
      end
      chk(done == 1'b1 && t == busy + 1, "R8 done latency", t - 1, busy);
      chk(req_ready && nand_ce_n, "R8 idle at done", int'(nand_ce_n), 1);
      case (op)
         2'd0: begin
            chk(lg_n == 1, "R1 command strobe count", lg_n, 1);
            chk(lg_kind[0] == 2'b10 && lg_val[0] == cmd, "R1 command byte",
                int'({lg_kind[0], lg_val[0]}), int'({2'b10, cmd}));
         end
         2'd1: begin
            chk(lg_n == 5, "R2 address cycle count", lg_n, 5);
            for (int k = 0; k < 5; k++)
               chk(lg_kind[k] == 2'b01 && lg_val[k] == addr[8*k +: 8], "R2 address byte",
                   int'({lg_kind[k], lg_val[k]}), int'({2'b01, addr[8*k +: 8]}));
         end
         2'd2: begin
            chk(lg_n == nb, "R3 write byte count", lg_n, nb);
            chk(widx - wb == nb, "R3 write pops", widx - wb, nb);
            for (int k = 0; k < nb && k < 32; k++)
               chk(lg_kind[k] == 2'b00 && lg_val[k] == wgen(wb + k), "R3 written byte",
                   int'({lg_kind[k], lg_val[k]}), int'(wgen(wb + k)));
         end
         default: begin
            chk(lg_n == 0 && re_pulses == nb, "R4 read pulse count", re_pulses, nb);
            chk(rd_n == nb, "R4 read valid count", rd_n, nb);
            for (int k = 0; k < nb && k < 32; k++)
               chk(rd_log[k] == rgen(rb + k), "R4 read byte", int'(rd_log[k]), int'(rgen(rb + k)));
         end
      endcase
      @(negedge clk);
      chk(!done, "R8 done lasts one clock", int'(done), 0);
   endtask

   bit wd_fired = 0;
   initial begin
      #2000000;
      wd_fired = 1;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("  Simulation finished: %0d checks, %0d errors", n_chk + m_chk + 1, n_err + m_err + 1);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(nand_ce_n && nand_we_n && nand_re_n && !nand_cle && !nand_ale,
          "R8 reset bus lines idle", int'(nand_ce_n), 1);
      chk(!nand_dq_oe && req_ready && !done && !rd_valid && !wr_pop,
          "R8 reset outputs", int'(nand_dq_oe), 0);
      for (int c = 0; c < 16; c++) run(2'd0, 8'(c * 17), 40'd0, 0);           // R1
      for (int b = 0; b < 40; b++) run(2'd1, 8'd0, 40'd1 << b, 0);             // R2
      run(2'd1, 8'd0, 40'd0, 0);
      run(2'd1, 8'd0, {40{1'b1}}, 0);
      run(2'd1, 8'd0, 40'h05_04_03_02_01, 0);
      for (int l = 0; l < 16; l++) run(2'd2, 8'd0, 40'd0, l);                  // R3
      for (int l = 0; l < 16; l++) run(2'd3, 8'd0, 40'd0, l);                  // R4
      run(2'd0, 8'h70, 40'd0, 0);
      run(2'd3, 8'd0, 40'd0, 3);
      run(2'd2, 8'd0, 40'd0, 2);
      if (!wd_fired) begin
         $display("  Simulation finished: %0d checks, %0d errors", n_chk + m_chk, n_err + m_err);
         $finish;
      end
   end

endmodule